// File: doc/BRIEF.md
# Interrupt Source Bank with Message and Level Sources

This block holds a parameterised bank of interrupt sources and hands their interrupts, one at a time, to a presentation controller. Each source is either message-signalled, where an input pulse is one event, or level-sensitive, where an input is a held request. The type of every source is fixed by a parameter mask and does not change with reset. A configuration write sets a source's target server, its priority and a saved priority. A priority of 0xFF masks the source.

Offers leave on a registered port that carries a global source number, the server and the priority. The global number is a base parameter plus the local index. The controller answers through three strobes. A reject names a source it turned away. An end-of-interrupt names a source whose service is finished. A resend asks the bank to walk all sources again, one per cycle, and re-offer what is still owed. Per-source status records masked events, rejected messages, and level requests that are asserted or already sent. A combinational read port shows the configuration and status of one selected source.

Top module: `isrc_bank`

## Requirements
- R1: After reset, every source has priority 0xFF, saved priority 0xFF, server 0 and a clear status, and no offer is valid.
- R2: A message event on a source whose priority is not 0xFF is offered two clock edges after it is sampled. The offer carries number BASE+index and the source's server and priority. With priority 0xFF, the event instead sets masked-pending (status bit 3) and nothing is offered.
- R3: A configuration write to a message source with masked-pending set and a new priority other than 0xFF clears masked-pending and offers the source. A write with priority 0xFF leaves masked-pending set.
- R4: A level source copies its input into asserted (status bit 0). On an input change, if the priority is not 0xFF, the input is high and sent (status bit 1) is clear, the source sets sent and is offered. While sent is set, no further offer is made.
- R5: A reject for a message source sets rejected (status bit 2). A reject for a level source clears sent without re-offering it until a later trigger.
- R6: An end-of-interrupt for a level source clears sent and does not by itself re-offer the source. An end-of-interrupt for a message source changes nothing.
- R7: A resend request starts a scan on the next edge that visits source k on the (k+2)-th edge after the request. A level source visited applies the rule of R4. A message source visited with rejected set clears it and is re-offered if its priority is not 0xFF.
- R8: A configuration write to a level source applies the rule of R4 using the newly written priority.
- R9: At most one offer is valid per cycle, and each offer lasts one cycle. The lowest pending index goes first. A request for a source that is still waiting merges with the one already waiting.
- R10: Reject and end-of-interrupt strobes whose number lies outside BASE..BASE+NSRC-1 change nothing.
- R11: Message pulses on level sources and level inputs on message sources have no effect. Level sources never show bits 2 or 3, and message sources never show bits 0 or 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| msi_evt | input | NSRC | One-cycle event pulses for message sources |
| lvl_in | input | NSRC | Request levels for level sources |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | IDXW | Local index written |
| cfg_server | input | SRVW | Server to store |
| cfg_prio | input | 8 | Priority to store |
| cfg_saved | input | 8 | Saved priority to store |
| rej_vld | input | 1 | Reject strobe |
| rej_num | input | NUMW | Global number rejected |
| eoi_vld | input | 1 | End-of-interrupt strobe |
| eoi_num | input | NUMW | Global number finished |
| resend_req | input | 1 | Start a resend scan |
| offer_vld | output | 1 | Offer valid |
| offer_num | output | NUMW | Global number offered |
| offer_server | output | SRVW | Target server of the offer |
| offer_prio | output | 8 | Priority of the offer |
| rd_idx | input | IDXW | Source selected for readback |
| rd_server | output | SRVW | Server of the selected source |
| rd_prio | output | 8 | Priority of the selected source |
| rd_saved | output | 8 | Saved priority of the selected source |
| rd_stat | output | 4 | Status: bit0 asserted, bit1 sent, bit2 rejected, bit3 masked-pending |

## Verification
The hardest state to reach is a rejected message source that is re-offered at the exact edge the resend scan visits it, while a level source further down the bank is also owed an offer. The stimulus builds this up in order: it masks a source to get masked-pending, unmasks it, rejects its offer, then raises and retires levels with end-of-interrupt before requesting a resend. A behavioural model then follows a long random run in which strobes, writes, out-of-range numbers and scans land in the same cycles. The offer port and the readback port are compared with the model every cycle.

// File: rtl/isrc_bank.sv
module isrc_bank #(
  parameter int NSRC = 16,
  parameter int SRVW = 8,
  parameter int NUMW = 16,
  parameter logic [NUMW-1:0] BASE = 16'h1000,
  parameter logic [NSRC-1:0] LSI_MASK = 16'hFF00,
  localparam int IDXW = $clog2(NSRC)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] msi_evt,
  input  logic [NSRC-1:0] lvl_in,
  input  logic            cfg_we,
  input  logic [IDXW-1:0] cfg_idx,
  input  logic [SRVW-1:0] cfg_server,
  input  logic [7:0]      cfg_prio,
  input  logic [7:0]      cfg_saved,
  input  logic            rej_vld,
  input  logic [NUMW-1:0] rej_num,
  input  logic            eoi_vld,
  input  logic [NUMW-1:0] eoi_num,
  input  logic            resend_req,
  output logic            offer_vld,
  output logic [NUMW-1:0] offer_num,
  output logic [SRVW-1:0] offer_server,
  output logic [7:0]      offer_prio,
  input  logic [IDXW-1:0] rd_idx,
  output logic [SRVW-1:0] rd_server,
  output logic [7:0]      rd_prio,
  output logic [7:0]      rd_saved,
  output logic [3:0]      rd_stat
);
  localparam logic [NUMW-1:0] NSRC_N = NUMW'(NSRC);
  localparam logic [IDXW-1:0] LAST = IDXW'(NSRC - 1);

  logic [SRVW-1:0] srv [NSRC];
  logic [7:0]      pri [NSRC];
  logic [7:0]      sav [NSRC];
  logic [NSRC-1:0] asrt, sent, rejd, mpnd, q;
  logic [NSRC-1:0] nx_asrt, nx_sent, nx_rejd, nx_mpnd, nx_q;
  logic            scan_on;
  logic [IDXW-1:0] scan_ix;
  logic [IDXW-1:0] pick;

  wire q_any = |q;
  wire [NUMW-1:0] rej_loc = rej_num - BASE;
  wire [NUMW-1:0] eoi_loc = eoi_num - BASE;
  wire rej_in = rej_vld && (rej_num >= BASE) && (rej_loc < NSRC_N);
  wire eoi_in = eoi_vld && (eoi_num >= BASE) && (eoi_loc < NSRC_N);
  wire [IDXW-1:0] rej_ix = rej_loc[IDXW-1:0];
  wire [IDXW-1:0] eoi_ix = eoi_loc[IDXW-1:0];
  wire unused_ok = ^(msi_evt & LSI_MASK) ^ ^(lvl_in & ~LSI_MASK);

  always_comb begin
    pick = '0;
    for (int k = NSRC - 1; k >= 0; k--)
      if (q[k]) pick = IDXW'(k);
  end

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    localparam logic [IDXW-1:0] GI = IDXW'(g);
    wire       cfg_hit  = cfg_we && (cfg_idx == GI);
    wire [7:0] pn       = cfg_hit ? cfg_prio : pri[g];
    wire       on       = (pn != 8'hFF);
    wire       scan_hit = scan_on && (scan_ix == GI);
    wire       rj       = rej_in && (rej_ix == GI);
    wire       eo       = eoi_in && (eoi_ix == GI);
    wire       tk       = q_any && (pick == GI);
    if (LSI_MASK[g]) begin : g_lvl
      wire sent_c = sent[g] & ~rj & ~eo;
      wire trig   = (lvl_in[g] != asrt[g]) | cfg_hit | scan_hit;
      wire fire   = trig & on & lvl_in[g] & ~sent_c;
      assign nx_asrt[g] = lvl_in[g];
      assign nx_sent[g] = sent_c | fire;
      assign nx_rejd[g] = 1'b0;
      assign nx_mpnd[g] = 1'b0;
      assign nx_q[g]    = (q[g] & ~tk) | fire;
    end else begin : g_msg
      wire rel = cfg_hit & mpnd[g] & on;
      wire rs  = scan_hit & rejd[g] & on;
      assign nx_asrt[g] = 1'b0;
      assign nx_sent[g] = 1'b0;
      assign nx_rejd[g] = (rejd[g] & ~scan_hit) | rj;
      assign nx_mpnd[g] = (mpnd[g] & ~rel) | (msi_evt[g] & ~on);
      assign nx_q[g]    = (q[g] & ~tk) | (msi_evt[g] & on) | rel | rs;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NSRC; k++) begin
        srv[k] <= '0;
        pri[k] <= 8'hFF;
        sav[k] <= 8'hFF;
      end
    end else if (cfg_we) begin
      srv[cfg_idx] <= cfg_server;
      pri[cfg_idx] <= cfg_prio;
      sav[cfg_idx] <= cfg_saved;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      asrt <= '0;
      sent <= '0;
      rejd <= '0;
      mpnd <= '0;
      q    <= '0;
    end else begin
      asrt <= nx_asrt;
      sent <= nx_sent;
      rejd <= nx_rejd;
      mpnd <= nx_mpnd;
      q    <= nx_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scan_on <= 1'b0;
      scan_ix <= '0;
    end else if (resend_req) begin
      scan_on <= 1'b1;
      scan_ix <= '0;
    end else if (scan_on) begin
      scan_on <= (scan_ix != LAST);
      scan_ix <= scan_ix + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      offer_vld    <= 1'b0;
      offer_num    <= '0;
      offer_server <= '0;
      offer_prio   <= 8'hFF;
    end else begin
      offer_vld    <= q_any;
      offer_num    <= BASE + NUMW'(pick);
      offer_server <= srv[pick];
      offer_prio   <= pri[pick];
    end
  end

  assign rd_server = srv[rd_idx];
  assign rd_prio   = pri[rd_idx];
  assign rd_saved  = sav[rd_idx];
  assign rd_stat   = {mpnd[rd_idx], rejd[rd_idx], sent[rd_idx], asrt[rd_idx] ^ (unused_ok & 1'b0)};
endmodule

// File: rtl/isrc_bank_chk.sv
module isrc_bank_chk #(
  parameter int NSRC = 16,
  parameter int NUMW = 16,
  parameter logic [NUMW-1:0] BASE = 16'h1000,
  parameter logic [NSRC-1:0] LSI_MASK = 16'hFF00,
  parameter int IDXW = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            offer_vld,
  input logic [NUMW-1:0] offer_num,
  input logic [IDXW-1:0] rd_idx,
  input logic [7:0]      rd_prio,
  input logic [7:0]      rd_saved,
  input logic [3:0]      rd_stat
);
  localparam logic [NUMW-1:0] NSRC_N = NUMW'(NSRC);

  AST_OFFER_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    offer_vld |-> (offer_num >= BASE) && ((offer_num - BASE) < NSRC_N)); // R2
  AST_RESET_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (rd_prio == 8'hFF) && (rd_saved == 8'hFF) && (rd_stat == 4'd0) && !offer_vld); // R1
  AST_MSG_NO_LEVEL_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    !LSI_MASK[rd_idx] |-> (rd_stat[1:0] == 2'b00)); // R11
  AST_LVL_NO_MSG_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    LSI_MASK[rd_idx] |-> (rd_stat[3:2] == 2'b00)); // R11
endmodule

bind isrc_bank isrc_bank_chk #(
  .NSRC(NSRC), .NUMW(NUMW), .BASE(BASE), .LSI_MASK(LSI_MASK), .IDXW(IDXW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .offer_vld(offer_vld), .offer_num(offer_num),
  .rd_idx(rd_idx), .rd_prio(rd_prio), .rd_saved(rd_saved), .rd_stat(rd_stat)
);

// File: tb/isrc_bank_tb.sv
`timescale 1ns/1ps
module isrc_bank_tb;
  localparam int NSRC = 16;
  localparam int SRVW = 8;
  localparam int NUMW = 16;
  localparam int IDXW = 4;
  localparam logic [NUMW-1:0] BASE = 16'h1000;
  localparam logic [NSRC-1:0] LSI_MASK = 16'hFF00;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NSRC-1:0] msi_evt = '0, lvl_in = '0;
  logic cfg_we = 1'b0;
  logic [IDXW-1:0] cfg_idx = '0;
  logic [SRVW-1:0] cfg_server = '0;
  logic [7:0] cfg_prio = '0, cfg_saved = '0;
  logic rej_vld = 1'b0, eoi_vld = 1'b0, resend_req = 1'b0;
  logic [NUMW-1:0] rej_num = '0, eoi_num = '0;
  logic offer_vld;
  logic [NUMW-1:0] offer_num;
  logic [SRVW-1:0] offer_server;
  logic [7:0] offer_prio;
  logic [IDXW-1:0] rd_idx = '0;
  logic [SRVW-1:0] rd_server;
  logic [7:0] rd_prio, rd_saved;
  logic [3:0] rd_stat;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  isrc_bank u_dut (
    .clk(clk), .rst_n(rst_n), .msi_evt(msi_evt), .lvl_in(lvl_in),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_server(cfg_server),
    .cfg_prio(cfg_prio), .cfg_saved(cfg_saved),
    .rej_vld(rej_vld), .rej_num(rej_num), .eoi_vld(eoi_vld), .eoi_num(eoi_num),
    .resend_req(resend_req),
    .offer_vld(offer_vld), .offer_num(offer_num), .offer_server(offer_server),
    .offer_prio(offer_prio),
    .rd_idx(rd_idx), .rd_server(rd_server), .rd_prio(rd_prio),
    .rd_saved(rd_saved), .rd_stat(rd_stat)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model
  logic [7:0] m_pri [NSRC];
  logic [7:0] m_sav [NSRC];
  logic [SRVW-1:0] m_srv [NSRC];
  bit m_as [NSRC], m_se [NSRC], m_rj [NSRC], m_mp [NSRC], m_pd [NSRC];
  bit m_scan;
  int m_six;
  bit m_ov;
  logic [NUMW-1:0] m_onum;
  logic [SRVW-1:0] m_osrv;
  logic [7:0] m_opri;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < NSRC; k++) begin
        m_pri[k] = 8'hFF; m_sav[k] = 8'hFF; m_srv[k] = '0;
        m_as[k] = 0; m_se[k] = 0; m_rj[k] = 0; m_mp[k] = 0; m_pd[k] = 0;
      end
      m_scan = 0; m_six = 0; m_ov = 0; m_onum = '0; m_osrv = '0; m_opri = 8'hFF;
    end else begin
      m_ov = 0;
      for (int k = 0; k < NSRC; k++) begin
        if (m_pd[k] && !m_ov) begin
          m_ov = 1; m_onum = BASE + NUMW'(k); m_osrv = m_srv[k]; m_opri = m_pri[k]; m_pd[k] = 0;
        end
      end
      for (int k = 0; k < NSRC; k++) begin
        bit wr, en, sh, rj, eo, trig;
        logic [7:0] np;
        wr = cfg_we && (int'(cfg_idx) == k);
        np = wr ? cfg_prio : m_pri[k];
        en = (np != 8'hFF);
        sh = m_scan && (m_six == k);
        rj = rej_vld && (int'(rej_num) == int'(BASE) + k);
        eo = eoi_vld && (int'(eoi_num) == int'(BASE) + k);
        if (LSI_MASK[k]) begin
          trig = (lvl_in[k] != m_as[k]) || wr || sh;
          m_as[k] = lvl_in[k];
          if (rj || eo) m_se[k] = 0;
          if (trig && en && lvl_in[k] && !m_se[k]) begin
            m_se[k] = 1; m_pd[k] = 1;
          end
        end else begin
          if (wr && m_mp[k] && en) begin m_mp[k] = 0; m_pd[k] = 1; end
          if (msi_evt[k]) begin
            if (en) m_pd[k] = 1; else m_mp[k] = 1;
          end
          if (sh && m_rj[k]) begin
            m_rj[k] = 0;
            if (en) m_pd[k] = 1;
          end
          if (rj) m_rj[k] = 1;
        end
        if (wr) begin m_pri[k] = cfg_prio; m_sav[k] = cfg_saved; m_srv[k] = cfg_server; end
      end
      if (resend_req) begin m_scan = 1; m_six = 0; end
      else if (m_scan) begin
        if (m_six == NSRC - 1) m_scan = 0;
        m_six++;
      end
    end
  end

  // per-cycle comparison with the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [3:0] es;
      es = {m_mp[rd_idx], m_rj[rd_idx], m_se[rd_idx], m_as[rd_idx]};
      chk(offer_vld == m_ov, "R9 offer valid", 32'(offer_vld), 32'(m_ov));
      if (m_ov)
        chk({offer_num, offer_server, offer_prio} == {m_onum, m_osrv, m_opri},
            "R2 offer fields", {offer_num, offer_server, offer_prio}, {m_onum, m_osrv, m_opri});
      chk({rd_server, rd_prio, rd_saved, rd_stat} == {m_srv[rd_idx], m_pri[rd_idx], m_sav[rd_idx], es},
          "R11 readback", {rd_prio, rd_saved, 4'd0, rd_stat}, {m_pri[rd_idx], m_sav[rd_idx], 4'd0, es});
    end
  end

  task automatic nxt(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg(input int idx, input int sv, input logic [7:0] p);
    cfg_we = 1; cfg_idx = IDXW'(idx); cfg_server = SRVW'(sv); cfg_prio = p; cfg_saved = p ^ 8'h0F;
    nxt();
    cfg_we = 0;
  endtask

  task automatic pulse_msg(input logic [NSRC-1:0] m);
    msi_evt = m; nxt(); msi_evt = '0;
  endtask

  task automatic rej(input logic [NUMW-1:0] n);
    rej_vld = 1; rej_num = n; nxt(); rej_vld = 0;
  endtask

  task automatic eoi(input logic [NUMW-1:0] n);
    eoi_vld = 1; eoi_num = n; nxt(); eoi_vld = 0;
  endtask

  task automatic resend();
    resend_req = 1; nxt(); resend_req = 0;
  endtask

  task automatic stat_is(input int idx, input logic [3:0] e, input string tag);
    rd_idx = IDXW'(idx); #0.5;
    chk(rd_stat == e, tag, 32'(rd_stat), 32'(e));
  endtask

  task automatic offer_is(input logic [NUMW-1:0] n, input string tag);
    chk(offer_vld && offer_num == n, tag, {15'd0, offer_vld, offer_num}, {15'd0, 1'b1, n});
  endtask

  task automatic no_offer(input string tag);
    chk(!offer_vld, tag, 32'(offer_vld), 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    nxt(3);
    rst_n = 1;
    nxt();
    // R1 reset state
    for (int k = 0; k < NSRC; k++) begin
      rd_idx = IDXW'(k); #0.5;
      chk(rd_prio == 8'hFF && rd_saved == 8'hFF && rd_stat == 0 && rd_server == 0, "R1",
          {rd_prio, rd_saved, 12'd0, rd_stat}, {16'hFFFF, 16'd0});
    end
    no_offer("R1");
    nxt();
    // R2 masked event
    pulse_msg(16'h0004);
    stat_is(2, 4'b1000, "R2 masked-pending");
    nxt(); no_offer("R2 masked no offer");
    // R3 unmask releases
    cfg(2, 3, 8'd5);
    nxt(); offer_is(BASE + 2, "R3");
    chk(offer_server == 3 && offer_prio == 5, "R3 fields", {offer_server, offer_prio}, {8'd3, 8'd5});
    stat_is(2, 4'b0000, "R3 cleared");
    // R2 enabled event
    pulse_msg(16'h0004);
    nxt(); offer_is(BASE + 2, "R2");
    // R5 reject message
    rej(BASE + 2);
    stat_is(2, 4'b0100, "R5 rejected");
    // R10 out of range reject on wrapping number
    rej(BASE + 16'd16);
    rej(BASE - 16'd16);
    stat_is(0, 4'b0000, "R10 reject ignored");
    // R7 resend re-offers src 2
    resend();
    nxt(3); no_offer("R7 before visit");
    nxt(); offer_is(BASE + 2, "R7 msg");
    stat_is(2, 4'b0000, "R7 rejected cleared");
    nxt(16);
    // R4 level source 9
    cfg(9, 1, 8'd4);
    nxt(); no_offer("R4 idle level");
    lvl_in[9] = 1; nxt();
    stat_is(9, 4'b0011, "R4 asserted sent");
    nxt(); offer_is(BASE + 9, "R4");
    lvl_in[9] = 0; nxt();
    stat_is(9, 4'b0010, "R4 sent held");
    lvl_in[9] = 1; nxt(); nxt();
    no_offer("R4 blocked by sent");
    // R10 out of range EOI
    eoi(BASE + 16'd25);
    stat_is(9, 4'b0011, "R10 eoi ignored");
    // R6 EOI level
    eoi(BASE + 9);
    stat_is(9, 4'b0001, "R6 sent cleared");
    nxt(); no_offer("R6 no re-offer");
    // R7 resend level
    resend();
    nxt(11); offer_is(BASE + 9, "R7 level");
    nxt(6);
    // R5 reject level
    rej(BASE + 9);
    stat_is(9, 4'b0001, "R5 level sent cleared");
    nxt(); no_offer("R5 no re-offer");
    // R6 EOI on message
    rej(BASE + 2);
    eoi(BASE + 2);
    stat_is(2, 4'b0100, "R6 msg unchanged");
    resend();
    nxt(20);
    // R8 config on level source
    lvl_in[10] = 1; nxt(); nxt();
    no_offer("R8 masked level");
    stat_is(10, 4'b0001, "R8 asserted only");
    cfg(10, 2, 8'd7);
    nxt(); offer_is(BASE + 10, "R8");
    // R9 ordering and merging
    cfg(1, 0, 8'd2); cfg(3, 0, 8'd2); cfg(5, 0, 8'd2);
    pulse_msg(16'h002A);
    nxt(); offer_is(BASE + 1, "R9 first");
    nxt(); offer_is(BASE + 3, "R9 second");
    nxt(); offer_is(BASE + 5, "R9 third");
    nxt(); no_offer("R9 drained");
    pulse_msg(16'h000A);
    pulse_msg(16'h0008);
    offer_is(BASE + 1, "R9 merge a");
    nxt(); offer_is(BASE + 3, "R9 merge b");
    nxt(); no_offer("R9 merged");
    // R11 ignored inputs
    cfg(12, 0, 8'd3);
    pulse_msg(16'h1000);
    nxt(); no_offer("R11 pulse on level");
    cfg(4, 0, 8'd2);
    lvl_in[4] = 1; nxt(); nxt();
    no_offer("R11 level on msg");
    stat_is(4, 4'b0000, "R11 msg status");
    // random phase, compared with the model
    for (int c = 0; c < 3000; c++) begin
      msi_evt    = NSRC'($urandom) & NSRC'($urandom) & NSRC'($urandom);
      if ($urandom_range(0, 3) == 0) lvl_in = lvl_in ^ (NSRC'(1) << $urandom_range(0, NSRC - 1));
      cfg_we     = ($urandom_range(0, 5) == 0);
      cfg_idx    = IDXW'($urandom);
      cfg_server = SRVW'($urandom);
      cfg_prio   = ($urandom_range(0, 2) == 0) ? 8'hFF : 8'($urandom_range(0, 7));
      cfg_saved  = 8'($urandom);
      rej_vld    = ($urandom_range(0, 3) == 0);
      rej_num    = BASE - 16'd2 + 16'($urandom_range(0, 19));
      eoi_vld    = ($urandom_range(0, 3) == 0);
      eoi_num    = BASE - 16'd2 + 16'($urandom_range(0, 19));
      resend_req = ($urandom_range(0, 40) == 0);
      rd_idx     = IDXW'($urandom);
      nxt();
    end
    msi_evt = '0; cfg_we = 0; rej_vld = 0; eoi_vld = 0; resend_req = 0;
    nxt(20);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule